// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer with Lock Detection

This block takes a serial stream that has already been sampled once per bit. A strobe, `bit_vld`, marks each cycle that carries a new bit. On the line, each word is sent as a 12-bit frame: a start bit fixed at 1, ten payload bits, and a stop bit fixed at 0. The stop bit of one frame followed by the start bit of the next gives a guaranteed low-to-high edge. The block uses that edge as an embedded clock to find the frame boundary.

After power-up or reset, the block hunts for a low-to-high transition and treats it as a candidate frame boundary. It then checks the edge at the same bit phase frame after frame. Lock is declared only when the candidate has held for a fixed number of frames. From then on the block delivers one 10-bit word per frame, together with a word strobe and an active-low lock flag. If the edge goes missing in two frames in a row, the block drops lock and starts hunting again on its own. The first word after such a relock is marked as suspect, because the words received around the loss may be corrupt.

A synchronous active-low sleep input returns the block to its initial hunting state. An output-enable input masks the data-side outputs without touching acquisition.

Top module: `frame_deser`

## Requirements
- R1: A bit is consumed only in a cycle where `bit_vld` is 1. Idle cycles between bits change neither alignment nor output.
- R2: A frame edge is a 0 (stop) bit followed by a 1 (start) bit. The edge found while hunting counts as the first qualifying frame. Lock is declared only after the edge has been seen at the same phase in `QUAL_FRAMES` (default 80) consecutive frames.
- R3: `lock_n_o` is 0 when locked and 1 when unlocked. It falls in the same cycle in which `word_vld_o` pulses for the first valid word.
- R4: If the edge is missing while the candidate is being qualified, the block goes back to hunting and the qualify count starts again. A stream that begins at an arbitrary bit phase is still acquired.
- R5: While locked, a single missing edge is tolerated. A second consecutive miss makes `lock_n_o` rise one cycle after that frame's start position is sampled, and hunting resumes automatically.
- R6: While locked, `word_vld_o` is a one-cycle pulse in the cycle after each stop bit is sampled, once per frame.
- R7: The first payload bit after the start bit appears on `word_o[0]` and the last appears on `word_o[9]`. `word_o` holds its value between strobes.
- R8: While unlocked, including after reset, `word_o` is zero and `word_vld_o` is 0.
- R9: `suspect_o` pulses together with the first word strobe of a lock gained after a loss of lock. It does not pulse for the first lock after reset or sleep, or for later words.
- R10: When `sleep_n` is low at a clock edge, the block is unlocked with zeroed outputs from the next cycle onward. After `sleep_n` is released, a full new acquisition of `QUAL_FRAMES` frames is needed.
- R11: When `out_en` is 0, `word_o`, `word_vld_o` and `suspect_o` read as zero. Lock state and acquisition are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_n | input | 1 | Synchronous sleep, active low; forces re-initialisation |
| out_en | input | 1 | Enables the data-side outputs |
| bit_vld | input | 1 | Marks a cycle that carries a serial bit |
| bit_in | input | 1 | Serial bit value |
| word_o | output | 10 | Recovered payload word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| lock_n_o | output | 1 | Lock flag, 0 = locked |
| suspect_o | output | 1 | Marks the first word after a relock |

## Verification
A wrong bit phase or a wrong qualify count shows up on `lock_n_o` as a lock that comes one or more frames early or late. The bench therefore counts frames up to the exact lock frame rather than only waiting for lock. A wrong payload slot index gives a permuted `word_o` at the very first strobe. This is exposed with single-bit patterns at both ends of the word. A bad miss counter or a stale "loss seen" flag only becomes visible frames later, as a lock that survives two missing edges or as a `suspect_o` pulse on the wrong word. A behavioural model compared against the outputs every cycle catches such a fault in the cycle it first appears.

// File: rtl/fdes_pkg.sv
package fdes_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_QUAL = 2'd1,
        ST_LOCK = 2'd2
    } fdes_state_e;

endpackage

// File: rtl/fdes_lock.sv
module fdes_lock #(
    parameter int DATA_W      = 10,
    parameter int QUAL_FRAMES = 80,
    parameter int MISS_LIMIT  = 2,
    localparam int FRAME_W    = DATA_W + 2,
    localparam int POS_W      = $clog2(FRAME_W),
    localparam int CNT_W      = $clog2(QUAL_FRAMES + 1),
    localparam int MISS_W     = $clog2(MISS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [POS_W-1:0] pos_o,
    output logic             emit_o,
    output logic             first_bad_o,
    output logic             drop_o,
    output logic             lock_n_o
);
    import fdes_pkg::*;

    localparam logic [POS_W-1:0]  LAST_POS = POS_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0]  QUAL_MAX = CNT_W'(QUAL_FRAMES);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);

    typedef struct packed {
        fdes_state_e       st;
        logic [POS_W-1:0]  pos;
        logic [CNT_W-1:0]  qcnt;
        logic [MISS_W-1:0] miss;
        logic              prev;
        logic              lost;
        logic              lock_n;
    } lock_state_t;

    localparam lock_state_t INIT = '{st: ST_HUNT, pos: '0, qcnt: '0, miss: '0,
                                     prev: 1'b1, lost: 1'b0, lock_n: 1'b1};

    lock_state_t s_d, s_q;
    logic        edge_ok;
    logic        emit_d;
    logic        drop_d;

    always_comb begin
        s_d     = s_q;
        emit_d  = 1'b0;
        drop_d  = 1'b0;
        edge_ok = !s_q.prev && bit_in;
        if (!sleep_n) begin
            s_d = INIT;
        end else if (bit_vld) begin
            s_d.prev = bit_in;
            s_d.pos  = (s_q.pos == LAST_POS) ? '0 : s_q.pos + 1'b1;
            unique case (s_q.st)
                ST_HUNT: begin
                    if (edge_ok) begin
                        s_d.st   = ST_QUAL;
                        s_d.qcnt = CNT_W'(1);
                        s_d.pos  = POS_W'(1);
                    end
                end
                ST_QUAL: begin
                    if (s_q.pos == '0) begin
                        if (!edge_ok) begin
                            s_d.st   = ST_HUNT;
                            s_d.qcnt = '0;
                        end else if (s_q.qcnt != QUAL_MAX) begin
                            s_d.qcnt = s_q.qcnt + 1'b1;
                        end
                    end else if (s_q.pos == LAST_POS && s_q.qcnt == QUAL_MAX) begin
                        s_d.st     = ST_LOCK;
                        s_d.lock_n = 1'b0;
                        s_d.lost   = 1'b0;
                        emit_d     = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (s_q.pos == '0) begin
                        if (edge_ok) begin
                            s_d.miss = '0;
                        end else if (s_q.miss == MISS_TOP) begin
                            s_d.st     = ST_HUNT;
                            s_d.miss   = '0;
                            s_d.qcnt   = '0;
                            s_d.lock_n = 1'b1;
                            s_d.lost   = 1'b1;
                            drop_d     = 1'b1;
                        end else begin
                            s_d.miss = s_q.miss + 1'b1;
                        end
                    end else if (s_q.pos == LAST_POS) begin
                        emit_d = 1'b1;
                    end
                end
                default: s_d = INIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= INIT;
        else        s_q <= s_d;
    end

    assign pos_o       = s_q.pos;
    assign emit_o      = emit_d;
    assign first_bad_o = emit_d && (s_q.st == ST_QUAL) && s_q.lost;
    assign drop_o      = drop_d;
    assign lock_n_o    = s_q.lock_n;

endmodule

// File: rtl/fdes_collect.sv
module fdes_collect #(
    parameter int DATA_W = 10,
    localparam int POS_W = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] slot_d, slot_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_slot
        assign slot_d[i] = (bit_vld && pos == POS_W'(i + 1)) ? bit_in : slot_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign word_o = slot_q;

endmodule

// File: rtl/frame_deser.sv
module frame_deser #(
    parameter int DATA_W      = 10,
    parameter int QUAL_FRAMES = 80,
    parameter int MISS_LIMIT  = 2,
    localparam int POS_W      = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              out_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              lock_n_o,
    output logic              suspect_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              vld;
        logic              susp;
    } out_reg_t;

    out_reg_t          o_d, o_q;
    logic [POS_W-1:0]  pos;
    logic              emit;
    logic              first_bad;
    logic              drop;
    logic [DATA_W-1:0] gathered;

    fdes_lock #(
        .DATA_W     (DATA_W),
        .QUAL_FRAMES(QUAL_FRAMES),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_n    (sleep_n),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .pos_o      (pos),
        .emit_o     (emit),
        .first_bad_o(first_bad),
        .drop_o     (drop),
        .lock_n_o   (lock_n_o)
    );

    fdes_collect #(
        .DATA_W(DATA_W)
    ) u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_vld(bit_vld),
        .bit_in (bit_in),
        .pos    (pos),
        .word_o (gathered)
    );

    always_comb begin
        o_d      = o_q;
        o_d.vld  = emit;
        o_d.susp = first_bad;
        if (emit)      o_d.word = gathered;
        else if (drop) o_d.word = '0;
        if (!sleep_n)  o_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign word_o     = out_en ? o_q.word : '0;
    assign word_vld_o = out_en && o_q.vld;
    assign suspect_o  = out_en && o_q.susp;

endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              bit_vld,
    input logic              lock_n,
    input logic              vld,
    input logic              susp,
    input logic [DATA_W-1:0] word
);
    // R3
    lock_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> vld);

    // R8
    quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (!vld && word == '0));

    // R9
    suspect_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> vld);

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    // R10
    sleep_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> lock_n);

    // R1
    strobe_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld) |-> $past(bit_vld));

endmodule

bind frame_deser frame_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sleep_n(sleep_n),
    .bit_vld(bit_vld),
    .lock_n (lock_n_o),
    .vld    (o_q.vld),
    .susp   (o_q.susp),
    .word   (o_q.word)
);

// File: tb/frame_deser_test.sv
module frame_deser_test;
    localparam int DW = 10;
    localparam int QF = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_n = 1'b1;
    logic          out_en = 1'b1;
    logic          bit_vld = 1'b0;
    logic          bit_in = 1'b0;
    logic [DW-1:0] word_o;
    logic          word_vld_o;
    logic          lock_n_o;
    logic          suspect_o;

    int n_chk = 0;
    int n_fail = 0;
    int gap = 0;
    bit done = 1'b0;

    // behavioural reference state
    int          m_st = 0, m_pos = 0, m_cnt = 0, m_miss = 0;
    logic        m_prev = 1'b1, m_lost = 1'b0, m_lock_n = 1'b1;
    logic        m_vld = 1'b0, m_susp = 1'b0;
    logic [DW-1:0] m_acc = '0, m_word = '0;

    frame_deser #(.DATA_W(DW), .QUAL_FRAMES(QF)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .out_en(out_en),
        .bit_vld(bit_vld), .bit_in(bit_in), .word_o(word_o),
        .word_vld_o(word_vld_o), .lock_n_o(lock_n_o), .suspect_o(suspect_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit ok;
        int cur;
        m_vld  = 1'b0;
        m_susp = 1'b0;
        if (!rst_n || !sleep_n) begin
            m_st = 0; m_pos = 0; m_cnt = 0; m_miss = 0; m_prev = 1'b1;
            m_lost = 1'b0; m_lock_n = 1'b1; m_word = '0;
        end else if (bit_vld) begin
            ok  = (m_prev == 1'b0) && (bit_in == 1'b1);
            cur = m_pos;
            if (m_st == 0) begin
                if (ok) begin m_st = 1; m_cnt = 1; m_pos = 1; end
            end else begin
                if (cur >= 1 && cur <= DW) m_acc[cur-1] = bit_in;
                if (cur == 0) begin
                    if (m_st == 1) begin
                        if (ok) m_cnt++; else m_st = 0;
                    end else if (ok) begin
                        m_miss = 0;
                    end else begin
                        m_miss++;
                        if (m_miss == 2) begin
                            m_st = 0; m_miss = 0; m_lock_n = 1'b1;
                            m_word = '0; m_lost = 1'b1;
                        end
                    end
                end else if (cur == DW + 1) begin
                    if (m_st == 2 || (m_st == 1 && m_cnt >= QF)) begin
                        m_vld  = 1'b1;
                        m_word = m_acc;
                        if (m_st == 1) begin
                            m_susp = m_lost; m_lost = 1'b0;
                            m_lock_n = 1'b0; m_st = 2;
                        end
                    end
                end
                m_pos = (cur == DW + 1) ? 0 : cur + 1;
            end
            m_prev = bit_in;
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R3", "model lock_n", lock_n_o, m_lock_n);
            chk("R7", "model word", word_o, out_en ? m_word : 0);
            chk("R6", "model strobe", word_vld_o, out_en & m_vld);
            chk("R9", "model suspect", suspect_o, out_en & m_susp);
        end
    end

    task automatic put_bit(input logic b);
        repeat (gap) @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input bit good);
        put_bit(good);
        for (int i = 0; i < DW; i++) put_bit(d[i]);
        put_bit(1'b0);
    endtask

    task automatic good_frames(input int n);
        for (int i = 0; i < n; i++) send_frame(DW'($urandom), 1'b1);
    endtask

    task automatic nap();
        sleep_n = 1'b0;
        @(negedge clk);
        chk("R10", "lock_n in sleep", lock_n_o, 1);
        chk("R10", "word in sleep", word_o, 0);
        @(negedge clk);
        sleep_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset lock_n", lock_n_o, 1);
        chk("R8", "reset word", word_o, 0);
        chk("R8", "reset strobe", word_vld_o, 0);

        // R2: exact qualify count from a clean boundary
        repeat (4) put_bit(1'b1);
        put_bit(1'b0);
        good_frames(QF - 1);
        chk("R2", "unlocked after 79 frames", lock_n_o, 1);
        send_frame(10'h001, 1'b1);
        chk("R3", "lock with first word", lock_n_o, 0);
        chk("R6", "first strobe", word_vld_o, 1);
        chk("R7", "bit0 first", word_o, 1);
        chk("R9", "no suspect on first lock", suspect_o, 0);
        send_frame(10'h200, 1'b1);
        chk("R7", "bit9 last", word_o, 512);

        // R1: idle cycles between bits
        gap = 2;
        for (int k = 0; k < 3; k++) begin
            d = DW'($urandom);
            send_frame(d, 1'b1);
            chk("R1", "word with gaps", word_o, d);
        end
        gap = 0;
        @(negedge clk);
        chk("R7", "word held between strobes", word_o, d);

        // R5: one miss tolerated
        send_frame('0, 1'b0);
        chk("R5", "lock after one miss", lock_n_o, 0);
        d = 10'h155;
        send_frame(d, 1'b1);
        chk("R5", "word after one miss", word_o, d);

        // R5: two misses drop lock
        send_frame('0, 1'b0);
        send_frame('0, 1'b0);
        chk("R5", "unlocked after two misses", lock_n_o, 1);
        chk("R8", "word zero unlocked", word_o, 0);
        chk("R8", "no strobe unlocked", word_vld_o, 0);

        // R9: relock marks suspect
        good_frames(QF - 1);
        chk("R5", "relock not early", lock_n_o, 1);
        good_frames(1);
        chk("R5", "relocked", lock_n_o, 0);
        chk("R9", "suspect on relock", suspect_o, 1);
        good_frames(1);
        chk("R9", "suspect only once", suspect_o, 0);

        // R11: output enable masks data only
        out_en = 1'b0;
        send_frame(10'h3ff, 1'b1);
        chk("R11", "masked word", word_o, 0);
        chk("R11", "masked strobe", word_vld_o, 0);
        chk("R11", "lock unaffected", lock_n_o, 0);
        out_en = 1'b1;
        d = 10'h0f3;
        send_frame(d, 1'b1);
        chk("R11", "word after unmask", word_o, d);

        // R10: sleep forces a full new acquisition
        nap();
        put_bit(1'b0);
        good_frames(QF - 1);
        chk("R10", "no early lock after sleep", lock_n_o, 1);
        good_frames(1);
        chk("R10", "lock after sleep", lock_n_o, 0);
        chk("R9", "no suspect after sleep", suspect_o, 0);

        // R4: mismatch during qualify restarts the count
        nap();
        put_bit(1'b0);
        good_frames(40);
        send_frame('0, 1'b0);
        good_frames(QF - 1);
        chk("R4", "count restarted", lock_n_o, 1);
        good_frames(1);
        chk("R4", "lock after restart", lock_n_o, 0);

        // R4: arbitrary starting phase with random payload
        nap();
        for (int k = 0; k < 37; k++) put_bit(1'($urandom));
        good_frames(150);
        chk("R4", "acquired from random phase", lock_n_o, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule